// File: doc/BRIEF.md
# Accumulator Round and Saturate Unit

This unit takes a wide signed accumulator, given as an upper part and a 16-bit lower part, and turns it into a rounded 32-bit signed result for a pair of 16-bit registers. The two parts are joined into one 56-bit value and sign-extended. That value is shifted by a signed amount. A rounding constant of half an output LSB (0x8000) is added and the low 16 bits are dropped. Only bits 43:0 of what is left are kept, and they are read as a signed number that is clamped to the 32-bit signed range.

A one-cycle `start` pulse begins the operation. One clock later the unit drives two write ports, one for the upper half and one for the lower half. The upper half goes to an even register index n and the lower half to n+1. The unit holds two flags. F0 reports whether the latest operation saturated. F1 keeps the value F0 had before that operation. The register file and the instruction decode that would use these ports sit outside the unit.

Top module: `acc_round_sat`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both write enables are low and both flags read 0.
- R2: Both write enables are high for exactly the one cycle after a cycle with `start` high, and low in every other cycle.
- R3: The upper half is written to register `dst_idx` and the lower half to `dst_idx + 1`. `dst_idx` is expected to be even.
- R4: The 56-bit value is `{acc_hi, acc_lo}`, sign-extended from bit 55. A shift amount of zero or more shifts it left by that many bits.
- R5: A negative shift amount shifts the value right arithmetically by its magnitude, so the sign is kept.
- R6: After the shift, 0x8000 is added and the sum is shifted right by 16. A fraction of exactly one half rounds up, and anything less rounds down.
- R7: When the result is above 0x7FFFFFFF, the upper half is 0x7FFF, the lower half is 0xFFFF and F0 becomes 1.
- R8: When the result is below -0x80000000, the upper half is 0x8000, the lower half is 0x0000 and F0 becomes 1.
- R9: When the result is within range (both ends included), the upper half is result bits 31:16, the lower half is bits 15:0, and F0 becomes 0.
- R10: On every operation F1 takes the value F0 held just before it. When `start` is low, neither flag changes.
- R11: Only bits 43:0 of the rounded and dropped value are compared, read as a signed number. A value whose bit 43 is set counts as negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts one conversion of the current inputs |
| acc_hi | input | 40 | Upper accumulator part (bits 55:16) |
| acc_lo | input | 16 | Lower accumulator part (bits 15:0) |
| shamt | input | 5 | Signed shift amount: left when zero or more, right when negative |
| dst_idx | input | 4 | Even destination register index |
| wr_en_hi | output | 1 | Write enable for the upper half |
| wr_idx_hi | output | 4 | Register index for the upper half |
| wr_data_hi | output | 16 | Upper half of the result |
| wr_en_lo | output | 1 | Write enable for the lower half |
| wr_idx_lo | output | 4 | Register index for the lower half |
| wr_data_lo | output | 16 | Lower half of the result |
| flag_f0 | output | 1 | Saturation flag of the latest operation |
| flag_f1 | output | 1 | F0 as it was before the latest operation |

## Verification
Each result appears exactly one clock after its `start` pulse: data, indices, enables and both flags are all registered at the same edge. The bench drives inputs and raises `start` at a falling edge, then samples every output at the next falling edge, half a period after the capturing edge. One further falling edge later it confirms that the enables have dropped and the flags are unchanged. Flags are checked against a running model in the bench, so the F1 value expected for each vector is the F0 expected from the vector before it.

// File: rtl/acc_round_sat.sv
module acc_round_sat #(
  parameter int HI_W  = 40,
  parameter int LO_W  = 16,
  parameter int SH_W  = 5,
  parameter int IDX_W = 4,
  parameter int OUT_W = 32,
  parameter int CMP_W = 44
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [HI_W-1:0]         acc_hi,
  input  logic [LO_W-1:0]         acc_lo,
  input  logic signed [SH_W-1:0]  shamt,
  input  logic [IDX_W-1:0]        dst_idx,
  output logic                    wr_en_hi,
  output logic [IDX_W-1:0]        wr_idx_hi,
  output logic [OUT_W/2-1:0]      wr_data_hi,
  output logic                    wr_en_lo,
  output logic [IDX_W-1:0]        wr_idx_lo,
  output logic [OUT_W/2-1:0]      wr_data_lo,
  output logic                    flag_f0,
  output logic                    flag_f1
);
  localparam int ACC_W  = HI_W + LO_W;
  localparam int WIDE_W = ACC_W + 2**(SH_W-1);
  localparam int HALF_W = OUT_W / 2;
  localparam logic signed [CMP_W-1:0] MAX_V =
    {{(CMP_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [CMP_W-1:0] MIN_V =
    {{(CMP_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
  localparam logic [WIDE_W-1:0] RND_V = WIDE_W'(1) << (LO_W-1);
  localparam logic [HALF_W-1:0] ONES_H = {HALF_W{1'b1}};
  localparam logic [HALF_W-1:0] ZERO_H = {HALF_W{1'b0}};
  localparam logic [HALF_W-1:0] TOP_H  = {1'b1, {(HALF_W-1){1'b0}}};

  logic signed [WIDE_W-1:0] ext_v, shf_v;
  logic        [WIDE_W-1:0] rnd_v;
  logic        [SH_W-1:0]   neg_amt;
  logic signed [CMP_W-1:0]  cmp_v;
  logic                     too_big, too_small;

  assign ext_v   = {{(WIDE_W-ACC_W){acc_hi[HI_W-1]}}, acc_hi, acc_lo};
  assign neg_amt = -shamt;
  assign shf_v   = shamt[SH_W-1] ? (ext_v >>> neg_amt) : (ext_v << shamt[SH_W-1:0]);
  assign rnd_v   = shf_v + RND_V;
  assign cmp_v   = rnd_v[LO_W +: CMP_W];
  assign too_big   = cmp_v > MAX_V;
  assign too_small = cmp_v < MIN_V;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en_hi   <= 1'b0;
      wr_en_lo   <= 1'b0;
      wr_idx_hi  <= '0;
      wr_idx_lo  <= '0;
      wr_data_hi <= '0;
      wr_data_lo <= '0;
      flag_f0    <= 1'b0;
      flag_f1    <= 1'b0;
    end else begin
      wr_en_hi <= start;
      wr_en_lo <= start;
      if (start) begin
        wr_idx_hi <= dst_idx;
        wr_idx_lo <= dst_idx + IDX_W'(1);
        flag_f1   <= flag_f0;
        flag_f0   <= too_big | too_small;
        if (too_big) begin
          wr_data_hi <= ~TOP_H;
          wr_data_lo <= ONES_H;
        end else if (too_small) begin
          wr_data_hi <= TOP_H;
          wr_data_lo <= ZERO_H;
        end else begin
          wr_data_hi <= cmp_v[HALF_W +: HALF_W];
          wr_data_lo <= cmp_v[0 +: HALF_W];
        end
      end
    end
  end

  p_pulse_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (wr_en_hi && wr_en_lo));
  p_quiet_no_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!wr_en_hi && !wr_en_lo));
  p_pair_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_lo |-> (wr_idx_lo == wr_idx_hi + IDX_W'(1)));
  p_sat_bounds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_hi && flag_f0) |->
      ((wr_data_hi == ~TOP_H && wr_data_lo == ONES_H) ||
       (wr_data_hi == TOP_H && wr_data_lo == ZERO_H)));
  p_f1_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (flag_f1 == $past(flag_f0)));
  p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(flag_f0) && $stable(flag_f1)));
endmodule

// File: tb/tb_acc_round_sat.sv
module tb_acc_round_sat;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  typedef struct packed {
    logic [39:0] hi;
    logic [15:0] lo;
    logic [4:0]  sh;
    logic [3:0]  idx;
    logic [15:0] ehi;
    logic [15:0] elo;
    logic        ef0;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{40'h00_0001_2345, 16'h6789, 5'd0,  4'd0,  16'h0001, 16'h2345, 1'b0}, // R9 R4
    '{40'h00_0000_0000, 16'h8000, 5'd0,  4'd2,  16'h0000, 16'h0001, 1'b0}, // R6 half up
    '{40'h00_0000_0000, 16'h7FFF, 5'd0,  4'd4,  16'h0000, 16'h0000, 1'b0}, // R6 below half
    '{40'h00_0000_0001, 16'h0000, 5'd4,  4'd6,  16'h0000, 16'h0010, 1'b0}, // R4 left
    '{40'h00_0000_1000, 16'h0000, 5'h1C, 4'd8,  16'h0000, 16'h0100, 1'b0}, // R5 right
    '{40'hFF_FFFF_FFFF, 16'h0000, 5'd0,  4'd10, 16'hFFFF, 16'hFFFF, 1'b0}, // R9 negative
    '{40'hFF_FFFF_F000, 16'h0000, 5'h1C, 4'd12, 16'hFFFF, 16'hFF00, 1'b0}, // R5 arith
    '{40'h00_8000_0000, 16'h0000, 5'd0,  4'd14, 16'h7FFF, 16'hFFFF, 1'b1}, // R7
    '{40'h00_7FFF_FFFF, 16'h7FFF, 5'd0,  4'd0,  16'h7FFF, 16'hFFFF, 1'b0}, // R9 max edge
    '{40'h00_7FFF_FFFF, 16'h8000, 5'd0,  4'd2,  16'h7FFF, 16'hFFFF, 1'b1}, // R7 rounds over
    '{40'hFF_8000_0000, 16'h0000, 5'd0,  4'd4,  16'h8000, 16'h0000, 1'b0}, // R9 min edge
    '{40'hFF_7FFF_FFFF, 16'h0000, 5'd0,  4'd6,  16'h8000, 16'h0000, 1'b1}, // R8
    '{40'h01_0000_0000, 16'h0000, 5'd11, 4'd8,  16'h8000, 16'h0000, 1'b1}, // R11 bit 43
    '{40'h00_4000_0000, 16'h0000, 5'd1,  4'd10, 16'h7FFF, 16'hFFFF, 1'b1}  // R7 via shift
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [39:0] acc_hi = '0;
  logic [15:0] acc_lo = '0;
  logic signed [4:0] shamt = '0;
  logic [3:0]  dst_idx = '0;
  logic wr_en_hi, wr_en_lo, flag_f0, flag_f1;
  logic [3:0] wr_idx_hi, wr_idx_lo;
  logic [15:0] wr_data_hi, wr_data_lo;
  int checks = 0, errors = 0;
  logic model_f0 = 1'b0;
  bit done = 1'b0;

  acc_round_sat dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input vec_t v);
    @(negedge clk);
    acc_hi = v.hi; acc_lo = v.lo; shamt = v.sh; dst_idx = v.idx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 enables", {30'b0, wr_en_hi, wr_en_lo}, 32'h3);
    chk("R3 hi index", 32'(wr_idx_hi), 32'(v.idx));
    chk("R3 lo index", 32'(wr_idx_lo), 32'(v.idx + 4'd1));
    chk("R4-R9 data", {wr_data_hi, wr_data_lo}, {v.ehi, v.elo});
    chk("R7 R8 R9 F0", 32'(flag_f0), 32'(v.ef0));
    chk("R10 F1", 32'(flag_f1), 32'(model_f0));
    model_f0 = v.ef0;
    @(negedge clk);
    chk("R2 enables drop", {30'b0, wr_en_hi, wr_en_lo}, 32'h0);
    chk("R10 flags hold", {30'b0, flag_f1, flag_f0}, {30'b0, model_f0 ? 1'b0 : 1'b0, model_f0} | 32'(flag_f1) << 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset enables", {30'b0, wr_en_hi, wr_en_lo}, 32'h0);
    chk("R1 reset flags", {30'b0, flag_f1, flag_f0}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {28'b0, wr_en_hi, wr_en_lo, flag_f1, flag_f0}, 32'h0);
    for (int i = 0; i < NV; i++) run_op(VECS[i]);
    // R10: idle cycles with changing inputs must leave flags and enables alone
    acc_hi = 40'h00_0000_0000; shamt = 5'd0;
    repeat (4) @(negedge clk);
    chk("R10 idle F0", 32'(flag_f0), 32'(model_f0));
    chk("R2 idle enables", {30'b0, wr_en_hi, wr_en_lo}, 32'h0);
    // R10: two saturating ops back to back, F1 then follows a set F0
    run_op('{40'h00_8000_0000, 16'h0000, 5'd0, 4'd12, 16'h7FFF, 16'hFFFF, 1'b1});
    run_op('{40'h00_0000_0000, 16'h0000, 5'd0, 4'd14, 16'h0000, 16'h0000, 1'b0});
    // R1: reset in the middle clears flags
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset", {28'b0, wr_en_hi, wr_en_lo, flag_f1, flag_f0}, 32'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule